// File: doc/BRIEF.md
# Pipelined Burst Cache SRAM

This block is a synchronous single-port memory for a processor's secondary cache. The data word is 32 bits wide and is split into four 8-bit lanes. Each rising clock edge registers the address, the control inputs and the write data. From those the block decides whether the cycle starts a burst, continues one, suspends one or deselects the memory. A read delivers its word through an output register one clock after the edge that accepted it. A burst then produces the next three words of an aligned group of four on the following three edges.

The block accepts two address strobes. The processor-side strobe counts only while chip enable is active, and the cycle it starts never writes. The controller-side strobe always counts. The burst order inside the group is either linear or interleaved, and a separate address-generator submodule produces it. The data output is a plain value with a separate drive-enable signal. An asynchronous output enable and a sleep input can force that drive-enable low. The address width is a parameter so that a small array can be used.

The control state machine has two states. `ST_IDLE` means deselected and `ST_BURST` means a burst is open. The transitions are:
- `ST_IDLE` to `ST_BURST` when a selected start arrives.
- `ST_BURST` to `ST_BURST` on a selected start, which reloads the address, or on a cycle without a strobe, which continues the burst when advance is low and suspends it when advance is high.
- `ST_BURST` to `ST_IDLE` when a start arrives while the chip is not selected, or when sleep is high.
- `ST_IDLE` stays in `ST_IDLE` otherwise.

Top module: `pipe_burst_sram`

## Requirements
- R1: A start takes effect only when `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0 at the edge. A start with any of these failing opens no access, and the outputs do not drive.
- R2: `cpu_strobe_n` low is ignored while `chip_en_n` is high, so a running burst continues. `ctl_strobe_n` low acts whatever `chip_en_n` is, and with `chip_en_n` high it deselects.
- R3: The word for an address loaded at edge k is on `rdata` with `rdata_oe`=1 after edge k+1. In a burst, the following words appear after edges k+2, k+3 and so on.
- R4: The burst changes only the low 2 address bits; the upper bits stay fixed. For base b and step n, `order_interleave`=0 gives (b+n) mod 4 and `order_interleave`=1 gives b XOR n. Past four steps the sequence wraps.
- R5: In a cycle without a strobe, `advance_n`=1 holds the burst address and `advance_n`=0 moves it one step. A strobe reloads the address whatever `advance_n` is.
- R6: `all_wr_n`=0 writes all four lanes and overrides the lane enables. If `all_wr_n`=1 and `lane_gate_n`=0, then `lane_wr_n[i]`=0 writes bits 8i+7:8i. If both `all_wr_n` and `lane_gate_n` are 1, nothing is written.
- R7: A cycle with `cpu_strobe_n`=0 writes nothing, whatever the write enables are.
- R8: After an edge that accepts a write, `rdata_oe` is 0 until the next edge.
- R9: `out_en_n`=1 forces `rdata_oe` to 0 at once, without waiting for a clock edge.
- R10: A deselect at edge k leaves the previous read on the outputs after edge k. After edge k+1, `rdata_oe` is 0.
- R11: `sleep`=1 forces `rdata_oe` to 0 at once and keeps the array contents. After sleep the block is deselected, and advance cycles start nothing until a new strobe arrives.
- R12: A read of an address in the cycle right after a write to it returns the newly written data.
- R13: After reset the block is deselected and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep request; forces deselect and holds contents |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| chip_en_n | input | 1 | Active-low chip enable; also qualifies the processor strobe |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Active-low burst advance |
| all_wr_n | input | 1 | Active-low write of all lanes |
| lane_gate_n | input | 1 | Active-low gate for the lane enables |
| lane_wr_n | input | 4 | Active-low per-lane write enables |
| order_interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The hardest situation to reach is a write in the middle of an open read burst. A suspend cycle with the global write enable low must silence the outputs right after its edge. The following suspended read must then return the new word. The bench opens a read, holds advance high and raises the write enable for one cycle, then samples the outputs on each of the next three edges. A similar sequence checks that deselect is single-cycle: a controller strobe with chip enable high is sent during a burst, and the bench checks that the old word stays valid for one more edge before the drive-enable drops.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } fsm_t;
endpackage

// File: rtl/pbs_burst_addr.sv
module pbs_burst_addr #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            hi_q   <= load_addr[ADDR_W-1:BURST_W];
            base_q <= load_addr[BURST_W-1:0];
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (interleave) low = base_q ^ cnt_q;
        else            low = base_q + cnt_q;
    end

    assign cur_addr = {hi_q, low};

    // R5: without load or step the address is held
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ((cur_addr == $past(cur_addr)) || (interleave != $past(interleave))));

    // R4: stepping never touches the upper address bits
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             chip_en_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             advance_n,
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             load,
    output logic             step,
    output op_t              op_q,
    output logic [LANES-1:0] lanes_q
);
    fsm_t             state_q, state_d;
    op_t              op_d;
    logic             selected, start, wr_now;
    logic [LANES-1:0] lanes_now;

    assign selected = !chip_en_n && sel_hi && !sel_lo_n;
    assign start    = (!cpu_strobe_n && !chip_en_n) || !ctl_strobe_n;

    always_comb begin
        if (!all_wr_n)         lanes_now = '1;
        else if (!lane_gate_n) lanes_now = ~lane_wr_n;
        else                   lanes_now = '0;
    end

    assign wr_now = (lanes_now != '0) && cpu_strobe_n;

    always_comb begin
        state_d = state_q;
        op_d    = OP_NONE;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && selected) begin
                    load    = 1'b1;
                    state_d = ST_BURST;
                    op_d    = wr_now ? OP_WRITE : OP_READ;
                end
            end
            ST_BURST: begin
                if (start) begin
                    if (selected) begin
                        load = 1'b1;
                        op_d = wr_now ? OP_WRITE : OP_READ;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    step = !advance_n;
                    op_d = wr_now ? OP_WRITE : OP_READ;
                end
            end
        endcase
        if (sleep) begin
            state_d = ST_IDLE;
            op_d    = OP_NONE;
            load    = 1'b0;
            step    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            lanes_q <= '0;
        end else begin
            op_q    <= op_d;
            lanes_q <= (op_d == OP_WRITE) ? lanes_now : '0;
        end
    end

    // R7: a processor-strobe cycle never produces a write
    a_r7_cpu_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strobe_n |=> (op_q != OP_WRITE));

    // R10: an unselected controller strobe closes the burst
    a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strobe_n && !(!chip_en_n && sel_hi && !sel_lo_n)) |=> (op_q == OP_NONE && state_q == ST_IDLE));

    // R11: sleep leaves the block deselected
    a_r11_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == ST_IDLE && op_q == OP_NONE));
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int LANE_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sleep,
    input  logic                       out_en_n,
    input  logic                       chip_en_n,
    input  logic                       sel_hi,
    input  logic                       sel_lo_n,
    input  logic                       cpu_strobe_n,
    input  logic                       ctl_strobe_n,
    input  logic                       advance_n,
    input  logic                       all_wr_n,
    input  logic                       lane_gate_n,
    input  logic [DATA_W/LANE_W-1:0]   lane_wr_n,
    input  logic                       order_interleave,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rdata_oe
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic              load, step;
    op_t               op_q;
    logic [LANES-1:0]  lanes_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] mem [DEPTH];

    pbs_ctrl #(.LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep        (sleep),
        .chip_en_n    (chip_en_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .advance_n    (advance_n),
        .all_wr_n     (all_wr_n),
        .lane_gate_n  (lane_gate_n),
        .lane_wr_n    (lane_wr_n),
        .load         (load),
        .step         (step),
        .op_q         (op_q),
        .lanes_q      (lanes_q)
    );

    pbs_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .interleave (order_interleave),
        .load_addr  (addr),
        .cur_addr   (cur_addr)
    );

    // write data captured on the edge that takes the write decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wdata_q <= '0;
        else if (!sleep) wdata_q <= wdata;
    end

    // commit stage: writes land at the end of the accepting cycle
    always_ff @(posedge clk) begin
        if (!sleep && op_q == OP_WRITE) begin
            for (int i = 0; i < LANES; i++) begin
                if (lanes_q[i])
                    mem[cur_addr][i*LANE_W +: LANE_W] <= wdata_q[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            rd_valid_q <= !sleep && (op_q == OP_READ);
            if (!sleep && op_q == OP_READ) rdata_q <= mem[cur_addr];
        end
    end

    assign rdata    = rdata_q;
    assign rdata_oe = !out_en_n && !sleep && rd_valid_q && (op_q != OP_WRITE);

    // R8: a pending write keeps the outputs silent
    a_r8_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> !rdata_oe);

    // R9: output enable high never lets the outputs drive
    a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);
endmodule

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n, sleep, out_en_n, chip_en_n, sel_hi, sel_lo_n;
    logic        cpu_strobe_n, ctl_strobe_n, advance_n, all_wr_n, lane_gate_n;
    logic [3:0]  lane_wr_n;
    logic        order_interleave;
    logic [AW-1:0] addr;
    logic [31:0] wdata, rdata;
    logic        rdata_oe;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [31:0] model [64];

    always #4 clk = ~clk;

    pipe_burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .out_en_n(out_en_n),
        .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .advance_n(advance_n), .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n),
        .lane_wr_n(lane_wr_n), .order_interleave(order_interleave),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [31:0] pat(int a);
        logic [7:0] b = a[7:0];
        return {8'hA5, b, 8'h5A, ~b};
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_data(string req, logic [31:0] exp);
        checks++;
        if (!(rdata_oe === 1'b1 && rdata === exp)) begin
            fails++;
            $display("FAIL %s: rdata=%h oe=%b, expected %h oe=1", req, rdata, rdata_oe, exp);
        end
    endtask

    task automatic chk_oe(string req, logic exp);
        checks++;
        if (rdata_oe !== exp) begin
            fails++;
            $display("FAIL %s: rdata_oe=%b, expected %b", req, rdata_oe, exp);
        end
    endtask

    task automatic defaults;
        sleep = 0; out_en_n = 0; chip_en_n = 0; sel_hi = 1; sel_lo_n = 0;
        cpu_strobe_n = 1; ctl_strobe_n = 1; advance_n = 1;
        all_wr_n = 1; lane_gate_n = 1; lane_wr_n = 4'hF;
        order_interleave = 0; addr = '0; wdata = '0;
    endtask

    task automatic do_write(int a, logic [31:0] d);
        addr = AW'(a); ctl_strobe_n = 0; all_wr_n = 0; wdata = d;
        tick;
        ctl_strobe_n = 1; all_wr_n = 1;
        model[a] = d;
    endtask

    task automatic start_read(int a);
        addr = AW'(a); ctl_strobe_n = 0;
        tick;
        ctl_strobe_n = 1;
    endtask

    task automatic t_reset;
        tick;
        chk_oe("R13 reset outputs silent", 1'b0);
        advance_n = 0; tick; tick;
        chk_oe("R13 advance after reset opens nothing", 1'b0);
        advance_n = 1;
    endtask

    task automatic t_preload;
        for (int a = 0; a < 64; a++) do_write(a, pat(a));
        tick;
    endtask

    task automatic t_select;
        addr = 6'd33; ctl_strobe_n = 0; sel_hi = 0; tick;
        ctl_strobe_n = 1; sel_hi = 1; tick;
        chk_oe("R1 strobe with sel_hi low", 1'b0);
        ctl_strobe_n = 0; sel_lo_n = 1; tick;
        ctl_strobe_n = 1; sel_lo_n = 0; tick;
        chk_oe("R1 strobe with sel_lo_n high", 1'b0);
        start_read(33); tick;
        chk_data("R1 selected start reads", model[33]);
    endtask

    task automatic t_linear_burst;
        int seq [5] = '{14, 15, 12, 13, 14};
        order_interleave = 0;
        start_read(14);
        advance_n = 0;
        for (int n = 0; n < 5; n++) begin
            tick;
            chk_data("R3 R4 linear burst word", model[seq[n]]);
        end
        advance_n = 1;
    endtask

    task automatic t_interleaved_burst;
        int seq [5] = '{17, 16, 19, 18, 17};
        order_interleave = 1;
        start_read(17);
        advance_n = 0;
        for (int n = 0; n < 5; n++) begin
            tick;
            chk_data("R4 interleaved burst word", model[seq[n]]);
        end
        advance_n = 1;
        order_interleave = 0;
    endtask

    task automatic t_suspend;
        start_read(4);
        advance_n = 0; tick;
        chk_data("R3 first word", model[4]);
        advance_n = 1; tick;
        chk_data("R5 advanced word", model[5]);
        tick;
        chk_data("R5 suspend holds", model[5]);
        advance_n = 0; addr = 6'd40; ctl_strobe_n = 0; tick;
        ctl_strobe_n = 1; advance_n = 1; tick;
        chk_data("R5 strobe overrides advance", model[40]);
    endtask

    task automatic t_lanes;
        addr = 6'd50; ctl_strobe_n = 0; lane_gate_n = 0; lane_wr_n = 4'b0101;
        wdata = 32'h11223344; tick;
        ctl_strobe_n = 1; lane_gate_n = 1; lane_wr_n = 4'hF;
        model[50] = {8'h11, model[50][23:16], 8'h33, model[50][7:0]};
        start_read(50); tick;
        chk_data("R6 lanes 1 and 3 written", model[50]);
        addr = 6'd51; ctl_strobe_n = 0; lane_wr_n = 4'h0; wdata = 32'hFFFFFFFF; tick;
        ctl_strobe_n = 1; lane_wr_n = 4'hF;
        start_read(51); tick;
        chk_data("R6 lane enables blocked by gate", model[51]);
    endtask

    task automatic t_cpu_no_write;
        addr = 6'd52; cpu_strobe_n = 0; all_wr_n = 0; wdata = 32'h0; tick;
        cpu_strobe_n = 1; all_wr_n = 1;
        start_read(52); tick;
        chk_data("R7 processor strobe cycle wrote nothing", model[52]);
    endtask

    task automatic t_burst_write;
        do_write(8, 32'hDEAD0008);
        advance_n = 0; all_wr_n = 0; wdata = 32'hBEEF0009; tick;
        model[9] = 32'hBEEF0009;
        advance_n = 1; all_wr_n = 1; tick;
        start_read(8);
        advance_n = 0; tick;
        chk_data("R3 burst write first word", model[8]);
        tick;
        chk_data("R5 burst write continued word", model[9]);
        advance_n = 1;
    endtask

    task automatic t_write_in_burst;
        start_read(20); tick;
        chk_data("R3 read before mid-burst write", model[20]);
        all_wr_n = 0; wdata = 32'h5EC0DA7A; tick;
        all_wr_n = 1; model[20] = 32'h5EC0DA7A;
        chk_oe("R8 write silences outputs", 1'b0);
        tick;
        chk_oe("R8 no read pending after write", 1'b0);
        tick;
        chk_data("R12 read right after write", model[20]);
    endtask

    task automatic t_raw_new_strobe;
        do_write(30, 32'h0BADF00D);
        chk_oe("R8 write edge silences outputs", 1'b0);
        start_read(30); tick;
        chk_data("R12 strobed read after write", model[30]);
    endtask

    task automatic t_oe;
        start_read(44); tick;
        out_en_n = 1; #1;
        chk_oe("R9 output enable high", 1'b0);
        out_en_n = 0; #1;
        chk_data("R9 output enable low again", model[44]);
    endtask

    task automatic t_strobes_and_deselect;
        start_read(60);
        cpu_strobe_n = 0; chip_en_n = 1; tick;
        cpu_strobe_n = 1; chip_en_n = 0;
        chk_data("R3 first word before ignored strobe", model[60]);
        tick;
        chk_data("R2 ungated processor strobe ignored", model[60]);
        ctl_strobe_n = 0; chip_en_n = 1; tick;
        ctl_strobe_n = 1; chip_en_n = 0;
        chk_data("R10 word still valid after deselect edge", model[60]);
        tick;
        chk_oe("R10 R2 silent one edge later", 1'b0);
        advance_n = 0; tick;
        chk_oe("R2 deselected stays silent", 1'b0);
        advance_n = 1;
    endtask

    task automatic t_sleep;
        start_read(61); tick;
        chk_data("R3 word before sleep", model[61]);
        sleep = 1; #1;
        chk_oe("R11 sleep silences outputs", 1'b0);
        tick; tick; tick;
        sleep = 0; advance_n = 0; tick; tick;
        chk_oe("R11 wakes deselected", 1'b0);
        advance_n = 1;
        start_read(61); tick;
        chk_data("R11 contents kept through sleep", model[61]);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        defaults;
        rst_n = 0;
        #20;
        rst_n = 1;
        #5;
        t_reset;
        t_preload;
        t_select;
        t_linear_burst;
        t_interleaved_burst;
        t_suspend;
        t_lanes;
        t_cpu_no_write;
        t_burst_write;
        t_write_in_burst;
        t_raw_new_strobe;
        t_oe;
        t_strobes_and_deselect;
        t_sleep;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule